// File: doc/BRIEF.md
# LCD Common Line Level Sequencer

This block decides, for every common line of a multiplexed liquid crystal panel, which drive level that line should carry during the current phase of the frame. It does not make voltages. It produces a 4-bit code per line, counted in twelfths of the panel supply, and an analog divider further down the chain turns that code into a voltage. Twelfths are used because they can express the half, third and quarter steps exactly.

A phase tick moves the frame on to its next phase. A frame tick starts a new frame at phase 0 and flips the polarity of the whole pattern, so that the mean voltage on the glass settles at half supply over each pair of frames. The duty input sets how many phases a frame has. The bias input picks the intermediate levels that lines hold while they are not selected.

In a non-inverted frame, the line whose index equals the current phase is driven to full supply and every other line sits at the low intermediate level. In an inverted frame, the selected line goes to ground and the others sit at the high intermediate level.

Top module: `lcdc_com_seq`

## Requirements
- R1: While reset is asserted, and after it is released, the sequencer is at phase 0 in the non-inverted polarity. Line 0 outputs code 12 and every other line outputs the low intermediate code for the present bias. Reset takes effect asynchronously and its release is synchronised through two flops.
- R2: A phase tick without a frame tick advances the phase by one. A phase tick taken at or beyond the last active phase (the value of duty_sel, limited to NUM_COM-1) returns the phase to 0.
- R3: A frame tick sets the phase to 0 and toggles the polarity. It wins over a phase tick in the same cycle.
- R4: In the non-inverted polarity, the selected line outputs 12. A non-selected line outputs the low code: 6, 4 or 3 for bias_sel 0 (half), 1 (third) or 2 (quarter).
- R5: In the inverted polarity, the selected line outputs 0. A non-selected line outputs the high code: 6, 8 or 9 for bias_sel 0, 1 or 2.
- R6: bias_sel value 3 gives the same codes as the quarter bias (value 2).
- R7: duty_sel = d gives d+1 active phases. A line whose index is greater than d is never selected and always holds the non-selected code. If the phase lies beyond d after duty_sel shrinks, no line is selected.
- R8: At most one line carries code 0 or 12 at any time, and every line code is one of 0, 3, 4, 6, 8, 9 or 12.
- R9: Without a frame tick, the polarity does not change.
- R10: For a given phase and bias, the codes one line shows in a non-inverted frame and in an inverted frame add up to 12.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| phase_tick | input | 1 | One-cycle pulse that advances to the next phase |
| frame_tick | input | 1 | One-cycle pulse that starts a new frame and flips polarity |
| duty_sel | input | $clog2(NUM_COM) | Index of the last active phase (number of phases minus one) |
| bias_sel | input | 2 | 0 half, 1 third, 2 or 3 quarter bias |
| com_level | output | NUM_COM*4 | Level code per line in twelfths of supply; line i in bits [4i+3:4i] |

## Verification
The assertions check, on every cycle, that the phase only steps by one or wraps to zero, that a frame tick restarts the phase and flips the polarity, that the polarity holds between frame ticks, that no more than one line is at an extreme level, and that every code is legal. Only the bench scenarios show that the right line is selected, that the intermediate code matches the chosen bias in each polarity, that the codes of a line in two opposite frames add up to half supply on average, that lines outside the active duty stay idle, and that a duty reduction in the middle of a frame is handled.

// File: rtl/lcdc_pkg.sv
package lcdc_pkg;
  localparam int LVL_W = 4;
  typedef logic [LVL_W-1:0] lvl_t;

  localparam lvl_t LVL_FULL = 4'd12;
  localparam lvl_t LVL_GND  = 4'd0;

  typedef enum logic [1:0] {
    BIAS_HALF    = 2'd0,
    BIAS_THIRD   = 2'd1,
    BIAS_QUARTER = 2'd2,
    BIAS_QALT    = 2'd3
  } bias_e;
endpackage

// File: rtl/lcdc_reset_sync.sv
module lcdc_reset_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_s
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_s = sync_q[1];
endmodule

// File: rtl/lcdc_phase_ctr.sv
module lcdc_phase_ctr #(
  parameter int NUM_COM = 8,
  localparam int PH_W   = $clog2(NUM_COM)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            phase_tick,
  input  logic            frame_tick,
  input  logic [PH_W-1:0] duty_sel,
  output logic [PH_W-1:0] phase,
  output logic            invert
);
  localparam logic [PH_W-1:0] LAST_MAX = PH_W'(NUM_COM - 1);

  logic [PH_W-1:0] last_c;
  logic [PH_W-1:0] phase_d;
  logic            invert_d;
  logic            ph_en;

  always_comb begin
    last_c   = (duty_sel > LAST_MAX) ? LAST_MAX : duty_sel;
    ph_en    = phase_tick | frame_tick;
    phase_d  = phase;
    invert_d = invert;
    if (frame_tick) begin
      phase_d  = '0;
      invert_d = ~invert;
    end else if (phase_tick) begin
      phase_d  = (phase >= last_c) ? '0 : phase + PH_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase  <= '0;
      invert <= 1'b0;
    end else if (ph_en) begin
      phase  <= phase_d;
      invert <= invert_d;
    end
  end

  // R2
  phase_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_tick && !frame_tick) |=> (phase == '0 || phase == $past(phase) + PH_W'(1)));

  // R3
  frame_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_tick |=> (phase == '0 && invert != $past(invert)));

  // R9
  pol_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_tick |=> $stable(invert));
endmodule

// File: rtl/lcdc_bias_lut.sv
module lcdc_bias_lut
  import lcdc_pkg::*;
(
  input  logic [1:0] bias_sel,
  input  logic       invert,
  output lvl_t       sel_lvl,
  output lvl_t       idle_lvl
);
  lvl_t low_lvl;

  always_comb begin
    unique case (bias_e'(bias_sel))
      BIAS_HALF:  low_lvl = 4'd6;
      BIAS_THIRD: low_lvl = 4'd4;
      default:    low_lvl = 4'd3;
    endcase
    sel_lvl  = invert ? LVL_GND : LVL_FULL;
    idle_lvl = invert ? (LVL_FULL - low_lvl) : low_lvl;
  end
endmodule

// File: rtl/lcdc_com_driver.sv
module lcdc_com_driver
  import lcdc_pkg::*;
#(
  parameter int NUM_COM = 8,
  parameter int IDX     = 0,
  localparam int PH_W   = $clog2(NUM_COM)
) (
  input  logic [PH_W-1:0] phase,
  input  logic [PH_W-1:0] duty_sel,
  input  lvl_t            sel_lvl,
  input  lvl_t            idle_lvl,
  output lvl_t            level,
  output logic            selected
);
  localparam logic [PH_W-1:0] MY_IDX = PH_W'(IDX);

  always_comb begin
    selected = (phase == MY_IDX) && (MY_IDX <= duty_sel);
    level    = selected ? sel_lvl : idle_lvl;
  end
endmodule

// File: rtl/lcdc_com_seq.sv
module lcdc_com_seq
  import lcdc_pkg::*;
#(
  parameter int NUM_COM = 8,
  localparam int PH_W   = $clog2(NUM_COM)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   phase_tick,
  input  logic                   frame_tick,
  input  logic [PH_W-1:0]        duty_sel,
  input  logic [1:0]             bias_sel,
  output logic [NUM_COM*LVL_W-1:0] com_level
);
  logic            rst_n_s;
  logic [PH_W-1:0] phase;
  logic            invert;
  lvl_t            sel_lvl;
  lvl_t            idle_lvl;
  logic [NUM_COM-1:0] sel_vec;

  lcdc_reset_sync u_rsync (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_n_s (rst_n_s)
  );

  lcdc_phase_ctr #(.NUM_COM(NUM_COM)) u_phase (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .phase_tick (phase_tick),
    .frame_tick (frame_tick),
    .duty_sel   (duty_sel),
    .phase      (phase),
    .invert     (invert)
  );

  lcdc_bias_lut u_lut (
    .bias_sel (bias_sel),
    .invert   (invert),
    .sel_lvl  (sel_lvl),
    .idle_lvl (idle_lvl)
  );

  for (genvar i = 0; i < NUM_COM; i++) begin : g_com
    lvl_t lvl_i;

    lcdc_com_driver #(.NUM_COM(NUM_COM), .IDX(i)) u_drv (
      .phase    (phase),
      .duty_sel (duty_sel),
      .sel_lvl  (sel_lvl),
      .idle_lvl (idle_lvl),
      .level    (lvl_i),
      .selected (sel_vec[i])
    );

    assign com_level[i*LVL_W +: LVL_W] = lvl_i;

    // R8
    level_legal_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
      (lvl_i == 4'd0 || lvl_i == 4'd3 || lvl_i == 4'd4 || lvl_i == 4'd6 ||
       lvl_i == 4'd8 || lvl_i == 4'd9 || lvl_i == 4'd12));
  end

  // R8
  one_sel_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    $countones(sel_vec) <= 1);
endmodule

// File: tb/sim_lcdc_com_seq.sv
module sim_lcdc_com_seq;
  localparam int NC = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic phase_tick = 1'b0;
  logic frame_tick = 1'b0;
  logic [2:0] duty_sel = 3'd3;
  logic [1:0] bias_sel = 2'd1;
  logic [NC*4-1:0] com_level;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  lcdc_com_seq #(.NUM_COM(NC)) u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .phase_tick (phase_tick),
    .frame_tick (frame_tick),
    .duty_sel   (duty_sel),
    .bias_sel   (bias_sel),
    .com_level  (com_level)
  );

  typedef struct packed {
    logic       pt;
    logic       ft;
    logic [2:0] duty;
    logic [1:0] bias;
    logic [2:0] ph;
    logic       inv;
  } vec_t;

  localparam vec_t VECS [16] = '{
    '{1'b1, 1'b0, 3'd3, 2'd1, 3'd1, 1'b0},  // R2 step
    '{1'b1, 1'b0, 3'd3, 2'd1, 3'd2, 1'b0},
    '{1'b1, 1'b0, 3'd3, 2'd1, 3'd3, 1'b0},
    '{1'b1, 1'b0, 3'd3, 2'd1, 3'd0, 1'b0},  // R2 wrap
    '{1'b0, 1'b1, 3'd3, 2'd1, 3'd0, 1'b1},  // R3 flip
    '{1'b1, 1'b0, 3'd3, 2'd2, 3'd1, 1'b1},  // R5 quarter
    '{1'b1, 1'b1, 3'd3, 2'd2, 3'd0, 1'b0},  // R3 precedence
    '{1'b1, 1'b0, 3'd7, 2'd0, 3'd1, 1'b0},  // R4 half
    '{1'b1, 1'b0, 3'd7, 2'd0, 3'd2, 1'b0},
    '{1'b1, 1'b0, 3'd7, 2'd0, 3'd3, 1'b0},
    '{1'b1, 1'b0, 3'd1, 2'd0, 3'd0, 1'b0},  // R7 shrink wraps
    '{1'b1, 1'b0, 3'd1, 2'd3, 3'd1, 1'b0},  // R6 alt code
    '{1'b1, 1'b0, 3'd1, 2'd3, 3'd0, 1'b0},
    '{1'b0, 1'b1, 3'd0, 2'd1, 3'd0, 1'b1},
    '{1'b1, 1'b0, 3'd0, 2'd1, 3'd0, 1'b1},  // R7 static
    '{1'b0, 1'b0, 3'd5, 2'd2, 3'd0, 1'b1}   // R9 hold
  };

  function automatic int low_code(input logic [1:0] b);
    case (b)
      2'd0:    return 6;
      2'd1:    return 4;
      default: return 3;  // R6
    endcase
  endfunction

  function automatic int exp_level(input int line, input int ph, input bit inv,
                                   input int duty, input logic [1:0] b);
    if (line <= duty && line == ph) return inv ? 0 : 12;
    return inv ? 12 - low_code(b) : low_code(b);
  endfunction

  function automatic int lvl(input int line);
    return int'(com_level[line*4 +: 4]);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic check_all(input int ph, input bit inv);
    int extremes = 0;
    for (int l = 0; l < NC; l++) begin
      string tag;
      if (l > int'(duty_sel)) tag = "R7";
      else if (inv)           tag = "R5";
      else                    tag = "R4";
      check(tag, lvl(l), exp_level(l, ph, inv, int'(duty_sel), bias_sel));
      if (lvl(l) == 0 || lvl(l) == 12) extremes++;
    end
    // R8
    check("R8", extremes, (ph <= int'(duty_sel)) ? 1 : 0);
  endtask

  task automatic tick(input logic pt, input logic ft);
    @(negedge clk);
    phase_tick = pt;
    frame_tick = ft;
    @(negedge clk);
    phase_tick = 1'b0;
    frame_tick = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    finish_run();
  end

  initial begin
    int sav [NC];
    // R1 during reset
    repeat (4) @(negedge clk);
    check_all(0, 1'b0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 after release
    check_all(0, 1'b0);

    foreach (VECS[k]) begin
      @(negedge clk);
      duty_sel = VECS[k].duty;
      bias_sel = VECS[k].bias;
      tick(VECS[k].pt, VECS[k].ft);
      check_all(int'(VECS[k].ph), VECS[k].inv);
    end

    // R1 asynchronous reset in mid-run
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check_all(0, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    duty_sel = 3'd2;
    bias_sel = 2'd2;
    repeat (4) @(negedge clk);

    // R10 opposite frames average to half supply, phase 0
    for (int l = 0; l < NC; l++) sav[l] = lvl(l);
    tick(1'b0, 1'b1);
    for (int l = 0; l < NC; l++) check("R10", sav[l] + lvl(l), 12);
    // R10 phase 1
    tick(1'b1, 1'b0);
    for (int l = 0; l < NC; l++) sav[l] = lvl(l);
    tick(1'b0, 1'b1);
    tick(1'b1, 1'b0);
    check_all(1, 1'b0);
    for (int l = 0; l < NC; l++) check("R10", sav[l] + lvl(l), 12);

    finish_run();
  end
endmodule